// File: doc/BRIEF.md
# Floating-point operand unpacker

This block turns one packed operand into the fields of a single internal number form. The form is the same for every source format, so arithmetic after it never has to know where an operand came from. A format select picks one of five source encodings: 32-bit and 64-bit two's-complement integers, and IEEE single, double and quad. The operand sits right-aligned on a 128-bit bus, and bits above the selected format's width are ignored.

The block produces the following fields:

- a sign;
- an unbiased signed exponent;
- a 128-bit mantissa whose leading one sits at bit 127 for every finite nonzero value;
- a class code;
- an invalid-operation flag.

Denormals and integers pass through a leading-zero count and a left shift, so they come out normalized. Signalling NaNs come out quiet and raise the invalid flag. A single register stage sits between the input strobe and the result strobe. A select code that names no format gives an error pulse in place of a result.

Top module: `fpu_unpack`

## Requirements
- R1: Format codes on `in_fmt` are 0 = int32, 1 = int64, 2 = single, 3 = double, 4 = quad. The operand occupies `in_op` from bit 0 upward, and higher bits are ignored. `out_sign` is the top bit of the selected width: bit 31, 63, 31, 63 or 127.
- R2: An integer operand of zero yields class zero, with mantissa 0 and exponent 0. A negative integer is converted to its magnitude, and the sign is reported separately; the most negative value has a magnitude of 2^31 or 2^63.
- R3: A nonzero integer magnitude yields class number. The exponent equals the bit position of the magnitude's highest one, and the mantissa is the magnitude shifted left until that one reaches bit 127.
- R4: An IEEE operand with exponent field 0 and fraction 0 yields class zero, with mantissa 0 and exponent 0. The sign is kept, so a negative zero reports sign 1.
- R5: An IEEE operand with exponent field 0 and a nonzero fraction is a denormal and yields class number. The fraction is placed just below bit 127 with no implied one, then shifted left by k places until bit 127 is set. The exponent is 1 − bias − k, where the bias is 127, 1023 or 16383.
- R6: An IEEE operand with exponent field neither 0 nor all ones yields class number. The exponent is the field minus the bias, and the mantissa is a one at bit 127 followed by the fraction bits, then zeros.
- R7: An IEEE operand with an all-ones exponent field and a zero fraction yields class infinity, with mantissa 0 and exponent 0. The sign is kept.
- R8: An all-ones exponent field with a nonzero fraction is a NaN, reported with exponent 0 and the fraction placed just below bit 127. If the top fraction bit is 1, the class is quiet NaN. If it is 0, the class is signalling NaN and mantissa bit 126 is forced to 1.
- R9: A result appears with `out_valid` high exactly one cycle after `in_valid` with a supported format. Operands may arrive on every cycle. `out_valid` is low in any cycle that follows a cycle with `in_valid` low.
- R10: When `in_valid` is high with format code 5, 6 or 7, the next cycle has `out_err` high and `out_valid` low, and the result fields keep their previous values.
- R11: While `rst_n` is low, every output is 0.
- R12: Class codes are 0 = zero, 1 = number, 2 = infinity, 3 = quiet NaN, 4 = signalling NaN. `out_invalid` is high exactly when the class is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_fmt | input | 3 | Source format select |
| in_op | input | 128 | Packed operand, right-aligned |
| out_valid | output | 1 | Result strobe |
| out_err | output | 1 | Unsupported format seen on the previous cycle |
| out_sign | output | 1 | Sign of the operand |
| out_exp | output | 18 | Unbiased exponent, two's complement |
| out_mant | output | 128 | Mantissa, leading one at bit 127 when normalized |
| out_class | output | 3 | Class code |
| out_invalid | output | 1 | Invalid-operation flag (signalling NaN input) |

## Verification
All state lives in one result register, so a fault in decode or normalization shows in the cycle right after the operand strobe. A miscounted leading-zero run shows as a clear bit 127 or an exponent off by the shift error. A wrong class decision shows as the wrong class with a mantissa that does not fit it, for example a nonzero mantissa on a zero. Denormal limits, most-negative integers and both NaN kinds in every IEEE width are where these faults show first. A dropped or extra strobe shows on `out_valid` or `out_err` one cycle after the input.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

    localparam int OP_W    = 128;
    localparam int MANT_W  = 128;
    localparam int EXP_W   = 18;
    localparam int FMT_W   = 3;
    localparam int NUM_FMT = 5;
    localparam int NUM_INT = 2;
    localparam int CLS_W   = 3;

    // per format code: exponent field width (0 for integers) and payload width
    localparam int FMT_EW [NUM_FMT] = '{0, 0, 8, 11, 15};
    localparam int FMT_FW [NUM_FMT] = '{32, 64, 23, 52, 112};

    typedef enum logic [CLS_W-1:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } cls_e;

    typedef struct packed {
        logic                     sign;
        logic signed [EXP_W-1:0]  exp;
        logic [MANT_W-1:0]        mant;
        cls_e                     cls;
    } unp_t;

endpackage

// File: rtl/fpu_unpack_decode.sv
module fpu_unpack_decode
    import fpu_unpack_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [FMT_W-1:0] fmt,
    output unp_t             pre,
    output logic             fmt_ok
);

    unp_t cand [NUM_FMT];

    for (genvar k = 0; k < NUM_FMT; k++) begin : g_fmt
        localparam int FW = FMT_FW[k];
        localparam int EW = FMT_EW[k];
        unp_t res;

        if (k < NUM_INT) begin : g_int
            logic [FW-1:0] raw;
            logic [FW-1:0] mag;
            assign raw = op[FW-1:0];
            assign mag = raw[FW-1] ? (FW'(0) - raw) : raw;
            always_comb begin
                res.sign = raw[FW-1];
                res.mant = MANT_W'(mag);
                if (mag == '0) begin
                    res.cls = CLS_ZERO;
                    res.exp = '0;
                end else begin
                    res.cls = CLS_NUM;
                    res.exp = EXP_W'(MANT_W - 1);
                end
            end
        end else begin : g_ieee
            localparam int BIAS = (1 << (EW - 1)) - 1;
            logic [EW-1:0] efld;
            logic [FW-1:0] frac;
            logic          e_zero;
            logic          e_ones;
            logic          f_zero;
            assign efld   = op[FW+EW-1:FW];
            assign frac   = op[FW-1:0];
            assign e_zero = (efld == '0);
            assign e_ones = &efld;
            assign f_zero = (frac == '0);
            always_comb begin
                res.sign = op[FW+EW];
                res.mant = {~e_zero & ~e_ones, frac, {(MANT_W-1-FW){1'b0}}};
                res.exp  = '0;
                res.cls  = CLS_NUM;
                if (e_ones) begin
                    if (f_zero) begin
                        res.cls = CLS_INF;
                    end else if (frac[FW-1]) begin
                        res.cls = CLS_QNAN;
                    end else begin
                        res.cls = CLS_SNAN;
                        res.mant[MANT_W-2] = 1'b1;
                    end
                end else if (e_zero) begin
                    if (f_zero) begin
                        res.cls = CLS_ZERO;
                    end else begin
                        res.exp = EXP_W'(1 - BIAS);
                    end
                end else begin
                    res.exp = EXP_W'(efld) - EXP_W'(BIAS);
                end
            end
        end

        assign cand[k] = res;
    end

    always_comb begin
        pre    = '0;
        fmt_ok = 1'b0;
        for (int k = 0; k < NUM_FMT; k++) begin
            if (fmt == FMT_W'(k)) begin
                pre    = cand[k];
                fmt_ok = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpu_unpack_lzc.sv
module fpu_unpack_lzc #(
    parameter int W  = 128,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    // highest set bit wins; an all-zero vector reports 0
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/fpu_unpack_norm.sv
module fpu_unpack_norm
    import fpu_unpack_pkg::*;
(
    input  unp_t pre,
    output unp_t post
);

    localparam int SH_W = $clog2(MANT_W);

    logic [SH_W-1:0] lz;
    logic [SH_W-1:0] shamt;

    fpu_unpack_lzc #(.W(MANT_W), .CW(SH_W)) lzc_i (
        .vec (pre.mant),
        .cnt (lz)
    );

    assign shamt = (pre.cls == CLS_NUM) ? lz : '0;

    always_comb begin
        post      = pre;
        post.mant = pre.mant << shamt;
        post.exp  = pre.exp - EXP_W'(shamt);
    end

endmodule

// File: rtl/fpu_unpack.sv
module fpu_unpack
    import fpu_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FMT_W-1:0]  in_fmt,
    input  logic [OP_W-1:0]   in_op,
    output logic              out_valid,
    output logic              out_err,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0] out_mant,
    output logic [CLS_W-1:0]  out_class,
    output logic              out_invalid
);

    unp_t pre;
    unp_t post;
    unp_t res_q;
    logic fmt_ok;
    logic vld_q;
    logic err_q;

    fpu_unpack_decode dec_i (
        .op     (in_op),
        .fmt    (in_fmt),
        .pre    (pre),
        .fmt_ok (fmt_ok)
    );

    fpu_unpack_norm norm_i (
        .pre  (pre),
        .post (post)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            err_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid & fmt_ok;
            err_q <= in_valid & ~fmt_ok;
            if (in_valid && fmt_ok) res_q <= post;
        end
    end

    assign out_valid   = vld_q;
    assign out_err     = err_q;
    assign out_sign    = res_q.sign;
    assign out_exp     = res_q.exp;
    assign out_mant    = res_q.mant;
    assign out_class   = res_q.cls;
    assign out_invalid = (res_q.cls == CLS_SNAN);

endmodule

// File: rtl/fpu_unpack_chk.sv
module fpu_unpack_chk
    import fpu_unpack_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [FMT_W-1:0]  in_fmt,
    input logic [OP_W-1:0]   in_op,
    input logic              out_valid,
    input logic              out_err,
    input logic              out_sign,
    input logic [EXP_W-1:0]  out_exp,
    input logic [MANT_W-1:0] out_mant,
    input logic [CLS_W-1:0]  out_class,
    input logic              out_invalid
);

    a_r9_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_fmt < FMT_W'(NUM_FMT)) |=> out_valid && !out_err);

    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_err);

    a_r10_bad_format: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_fmt >= FMT_W'(NUM_FMT)) |=> out_err && !out_valid);

    a_r10_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_fmt >= FMT_W'(NUM_FMT)) |=> $stable(out_mant) && $stable(out_class));

    a_r1_quad_sign: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_fmt == 3'd4) |=> out_sign == $past(in_op[127]));

    a_r3_leading_one: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_class == 3'd1) |-> out_mant[MANT_W-1]);

    a_r4_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_class == 3'd0) |-> (out_mant == '0) && (out_exp == '0));

    a_r7_inf_clean: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_class == 3'd2) |-> (out_mant == '0));

    a_r8_snan_quieted: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_class == 3'd4) |-> out_mant[MANT_W-2] && out_invalid);

    a_r12_invalid_only_snan: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_class == 3'd4));

    a_r12_class_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_class <= 3'd4));

    always_comb begin
        if (!rst_n) begin
            a_r11_no_strobe_in_reset: assert (!(out_valid && out_err));
        end
    end

endmodule

bind fpu_unpack fpu_unpack_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_fmt      (in_fmt),
    .in_op       (in_op),
    .out_valid   (out_valid),
    .out_err     (out_err),
    .out_sign    (out_sign),
    .out_exp     (out_exp),
    .out_mant    (out_mant),
    .out_class   (out_class),
    .out_invalid (out_invalid)
);

// File: tb/fpu_unpack_tb_top.sv
module fpu_unpack_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct packed {
        logic [2:0]          fmt;
        logic [127:0]        op;
        logic                sgn;
        logic [2:0]          cls;
        logic signed [31:0]  ex;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        // integers (R2, R3)
        '{3'd0, 128'h0, 1'b0, 3'd0, 32'sd0},
        '{3'd0, 128'h8000_0000, 1'b1, 3'd1, 32'sd31},
        '{3'd0, 128'hFFFF_FFFF, 1'b1, 3'd1, 32'sd0},
        '{3'd0, 128'h5, 1'b0, 3'd1, 32'sd2},
        '{3'd0, 128'h7FFF_FFFF, 1'b0, 3'd1, 32'sd30},
        '{3'd1, 128'h8000_0000_0000_0000, 1'b1, 3'd1, 32'sd63},
        '{3'd1, 128'h0, 1'b0, 3'd0, 32'sd0},
        '{3'd1, 128'h1_0000_0000, 1'b0, 3'd1, 32'sd32},
        // single (R4..R8)
        '{3'd2, 128'h8000_0000, 1'b1, 3'd0, 32'sd0},
        '{3'd2, 128'h1, 1'b0, 3'd1, -32'sd149},
        '{3'd2, 128'h007F_FFFF, 1'b0, 3'd1, -32'sd127},
        '{3'd2, 128'h3F80_0000, 1'b0, 3'd1, 32'sd0},
        '{3'd2, 128'h7F7F_FFFF, 1'b0, 3'd1, 32'sd127},
        '{3'd2, 128'hFF80_0000, 1'b1, 3'd2, 32'sd0},
        '{3'd2, 128'h7FC0_0000, 1'b0, 3'd3, 32'sd0},
        '{3'd2, 128'h7F80_0001, 1'b0, 3'd4, 32'sd0},
        // single with junk above bit 31 (R1)
        '{3'd2, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_3F80_0000, 1'b0, 3'd1, 32'sd0},
        // double
        '{3'd3, 128'h8000_0000_0000_0000, 1'b1, 3'd0, 32'sd0},
        '{3'd3, 128'h1, 1'b0, 3'd1, -32'sd1074},
        '{3'd3, 128'h000F_FFFF_FFFF_FFFF, 1'b0, 3'd1, -32'sd1023},
        '{3'd3, 128'hC000_0000_0000_0000, 1'b1, 3'd1, 32'sd1},
        '{3'd3, 128'h7FF0_0000_0000_0000, 1'b0, 3'd2, 32'sd0},
        '{3'd3, 128'h7FF8_0000_0000_0000, 1'b0, 3'd3, 32'sd0},
        '{3'd3, 128'h7FF0_0000_0000_0001, 1'b0, 3'd4, 32'sd0},
        // quad
        '{3'd4, 128'h1, 1'b0, 3'd1, -32'sd16494},
        '{3'd4, 128'h0000_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b0, 3'd1, -32'sd16383},
        '{3'd4, 128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 1'b0, 3'd1, 32'sd0},
        '{3'd4, 128'h7FFE_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b0, 3'd1, 32'sd16383},
        '{3'd4, 128'h7FFF_0000_0000_0000_0000_0000_0000_0000, 1'b0, 3'd2, 32'sd0},
        '{3'd4, 128'hFFFF_0000_0000_0000_0000_0000_0000_0000, 1'b1, 3'd2, 32'sd0},
        '{3'd4, 128'h7FFF_8000_0000_0000_0000_0000_0000_0000, 1'b0, 3'd3, 32'sd0},
        '{3'd4, 128'hFFFF_0000_0000_0000_0000_0000_0000_0001, 1'b1, 3'd4, 32'sd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   in_fmt = '0;
    logic [127:0] in_op = '0;
    logic         out_valid;
    logic         out_err;
    logic         out_sign;
    logic [17:0]  out_exp;
    logic [127:0] out_mant;
    logic [2:0]   out_class;
    logic         out_invalid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpu_unpack dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_fmt      (in_fmt),
        .in_op       (in_op),
        .out_valid   (out_valid),
        .out_err     (out_err),
        .out_sign    (out_sign),
        .out_exp     (out_exp),
        .out_mant    (out_mant),
        .out_class   (out_class),
        .out_invalid (out_invalid)
    );

    task automatic check(input string tag, input logic ok, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // behavioural mantissa model, built from the requirement text
    function automatic logic [127:0] model_mant(input logic [2:0] f, input logic [127:0] op);
        logic [127:0] m;
        logic [127:0] fr;
        logic [127:0] ef;
        int ew;
        int fw;
        m = '0;
        if (f == 3'd0 || f == 3'd1) begin
            fw = (f == 3'd0) ? 32 : 64;
            m  = op & ((128'd1 << fw) - 1);
            if (op[fw-1]) m = (128'd1 << fw) - m;
            if (m != 0) while (!m[127]) m = m << 1;
        end else begin
            case (f)
                3'd2:    begin ew = 8;  fw = 23;  end
                3'd3:    begin ew = 11; fw = 52;  end
                default: begin ew = 15; fw = 112; end
            endcase
            fr = op & ((128'd1 << fw) - 1);
            ef = (op >> fw) & ((128'd1 << ew) - 1);
            m  = fr << (127 - fw);
            if (ef == ((128'd1 << ew) - 1)) begin
                if (fr != 0) m[126] = 1'b1;
            end else begin
                if (ef != 0) m[127] = 1'b1;
                if (m != 0) while (!m[127]) m = m << 1;
            end
        end
        return m;
    endfunction

    function automatic string tag_of(input vec_t v);
        if (v.fmt < 3'd2) return (v.cls == 3'd0) ? "R2" : "R3";
        case (v.cls)
            3'd0: return "R4";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return "R8";
            default: begin
                if ((v.fmt == 3'd2 && v.op[30:23] == 0) ||
                    (v.fmt == 3'd3 && v.op[62:52] == 0) ||
                    (v.fmt == 3'd4 && v.op[126:112] == 0)) return "R5";
                return "R6";
            end
        endcase
    endfunction

    task automatic check_vec(input int idx, input vec_t v);
        logic [127:0] em;
        int ge;
        em = model_mant(v.fmt, v.op);
        ge = $signed(out_exp);
        check("R9", out_valid === 1'b1 && out_err === 1'b0,
              $sformatf("vec %0d valid=%b err=%b expected 1/0", idx, out_valid, out_err));
        check("R1", out_sign === v.sgn,
              $sformatf("vec %0d sign=%b expected %b", idx, out_sign, v.sgn));
        check("R12", out_class === v.cls && out_invalid === (v.cls == 3'd4),
              $sformatf("vec %0d class=%0d inv=%b expected %0d/%b",
                        idx, out_class, out_invalid, v.cls, v.cls == 3'd4));
        check(tag_of(v), out_mant === em && ge == v.ex,
              $sformatf("vec %0d mant=%h exp=%0d expected %h/%0d",
                        idx, out_mant, ge, em, v.ex));
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        logic [2:0] held_cls;
        logic [127:0] held_mant;

        // R11: outputs are zero while reset is held
        repeat (3) @(negedge clk);
        check("R11", {out_valid, out_err, out_sign, out_exp, out_mant, out_class, out_invalid} === '0,
              $sformatf("in reset valid=%b err=%b class=%0d mant=%h expected all 0",
                        out_valid, out_err, out_class, out_mant));
        rst_n = 1'b1;

        // vector table, streamed back to back (R9)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i > 0) check_vec(i - 1, VECS[i-1]);
            in_valid = 1'b1;
            in_fmt   = VECS[i].fmt;
            in_op    = VECS[i].op;
        end
        @(negedge clk);
        check_vec(NV - 1, VECS[NV-1]);
        in_valid = 1'b0;

        // R9: idle input gives no strobe
        @(negedge clk);
        check("R9", out_valid === 1'b0 && out_err === 1'b0,
              $sformatf("idle valid=%b err=%b expected 0/0", out_valid, out_err));

        // R10: unsupported codes raise error and leave fields alone
        held_cls  = out_class;
        held_mant = out_mant;
        for (int c = 5; c < 8; c++) begin
            in_valid = 1'b1;
            in_fmt   = 3'(c);
            in_op    = 128'h3F80_0000;
            @(negedge clk);
            check("R10", out_err === 1'b1 && out_valid === 1'b0,
                  $sformatf("fmt %0d err=%b valid=%b expected 1/0", c, out_err, out_valid));
            check("R10", out_class === held_cls && out_mant === held_mant,
                  $sformatf("fmt %0d class=%0d mant=%h expected held %0d/%h",
                            c, out_class, out_mant, held_cls, held_mant));
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R10", out_err === 1'b0,
              $sformatf("error pulse length err=%b expected 0", out_err));

        // R11: reset mid-run clears a live result
        in_valid = 1'b1;
        in_fmt   = 3'd4;
        in_op    = 128'hFFFF_0000_0000_0000_0000_0000_0000_0001;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R11", out_valid === 1'b0 && out_class === 3'd0 && out_invalid === 1'b0 && out_mant === '0,
              $sformatf("after reset valid=%b class=%0d inv=%b expected 0/0/0",
                        out_valid, out_class, out_invalid));
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule